// File: doc/BRIEF.md
# Single-Precision Result Packer

This block takes a floating-point result held in an unpacked working form and produces the final 32-bit IEEE-754 single-precision word. The input is a sign, a two-bit class, a signed unbiased exponent, and a 24-bit significand whose top bit is the explicit leading one. Three extra bits below the significand (guard, round, sticky) and a two-bit rounding mode come with it. The block adds the exponent bias. When the biased exponent is zero or negative, it shifts the significand right into the subnormal range. It then rounds in the selected mode, renormalises after a carry out of rounding, and replaces an out-of-range result with infinity or the largest finite value.

Four status flags come with each result: inexact, underflow, overflow and operand error. The data path is one registered stage with a valid/ready handshake on both sides. An input is taken on a rising edge where `in_valid` and `in_ready` are both high. Its packed result appears on the next cycle with `out_valid` high. `in_ready` is high whenever the output register is empty or is being drained in that cycle (`!out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, the output word and flags hold still and no new input is taken.

Top module: `fp32_packer`

## Requirements
- R1: A zero-class input (class code 00) packs as its sign bit with all other bits clear. It raises no flag, whatever the exponent, significand, rounding bits or mode.
- R2: An infinity-class input (class code 10) packs as its sign, exponent field 255 and a zero fraction. It raises no flag, and the rounding bits have no effect.
- R3: A NaN-class input (class code 11) packs as its sign, exponent field 255, and the 23 significand bits below the leading one unchanged. It raises no flag.
- R4: A number-class input (class code 01) whose biased exponent (unbiased + 127) is in 1..254, with guard, round and sticky all clear, packs exactly: the biased exponent goes in bits 30:23 and significand bits 22:0 in bits 22:0, with no flag.
- R5: Rounding mode codes are 00 nearest-even, 01 toward zero, 10 toward minus infinity and 11 toward plus infinity. Nearest-even rounds up when guard is set and any of round, sticky or the result LSB is set. Toward minus infinity rounds up only negative values, and toward plus infinity only positive ones. Any nonzero rounding bit sets the inexact flag (flag bit 0).
- R6: When rounding a normal value carries out of the significand, the exponent field rises by one and the fraction field is zero.
- R7: A biased exponent of 0 or less sets the underflow flag (flag bit 1). The significand, with its guard and round bits, shifts right by (1 - biased exponent), and every bit shifted out joins sticky. The result is rounded and packed with exponent field 0. Shifts beyond the whole width leave only sticky.
- R8: When rounding a subnormal carries into the leading-one position, the result is exponent field 1 with a zero fraction, and the underflow flag stays set.
- R9: A final biased exponent (after any rounding carry) of 255 or more is an overflow. It sets overflow (bit 2), inexact (bit 0) and operand error (bit 3), and no other case sets operand error.
- R10: On overflow the result is infinity for nearest-even, for toward plus infinity with a positive sign, and for toward minus infinity with a negative sign. Otherwise it is the signed largest finite value, exponent field 254 with an all-ones fraction.
- R11: An accepted input gives `out_valid` high on the next cycle. `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, the output word and flags stay unchanged. Reset clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Block can take an input this cycle |
| in_sign | input | 1 | Sign of the value, 1 = negative |
| in_class | input | 2 | 00 zero, 01 number, 10 infinity, 11 NaN |
| in_exp | input | 10 | Unbiased exponent, two's complement |
| in_mant | input | 24 | Significand, bit 23 the explicit leading one |
| in_guard | input | 1 | First bit below the significand |
| in_round | input | 1 | Second bit below the significand |
| in_sticky | input | 1 | OR of all lower bits |
| in_rmode | input | 2 | Rounding mode, encoding as in R5 |
| out_valid | output | 1 | Output word and flags are valid |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_word | output | 32 | Packed single-precision word |
| out_flags | output | 4 | {operand error, overflow, underflow, inexact} |

## Verification
On every valid output cycle, the assertions check the flag relationships. Operand error appears exactly with overflow, and both bring inexact with them. Underflow is seen only with an exponent field of 0 or 1, and an overflowed word carries exponent 254 or 255. An all-ones exponent without overflow carries no flags. The handshake rules of R11 are also checked every cycle. The exact bit patterns are shown only by the bench's scenarios. These cover the choice between rounding up and truncating in each mode, the tie-to-even case, the subnormal shift amounts including the clamp, the carry into the smallest normal, and the choice between infinity and the largest finite value.

// File: rtl/fp32_pack_pkg.sv
package fp32_pack_pkg;

  // Default field widths of the packed word and the unpacked input
  localparam int FRAC_W = 23;  // stored fraction bits
  localparam int EFLD_W = 8;   // exponent field bits
  localparam int IEXP_W = 10;  // unbiased input exponent bits

  typedef enum logic [1:0] {
    CLS_ZERO = 2'b00,
    CLS_NUM  = 2'b01,
    CLS_INF  = 2'b10,
    CLS_NAN  = 2'b11
  } fp_class_e;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_TOZERO  = 2'b01,
    RM_DOWN    = 2'b10,
    RM_UP      = 2'b11
  } rmode_e;

  typedef struct packed {
    logic operr;
    logic ovf;
    logic unf;
    logic inx;
  } fp_flags_t;

endpackage

// File: rtl/fp32_sticky_shift.sv
// Right shifter that ORs every bit pushed off the bottom into one flag.
module fp32_sticky_shift #(
  parameter int W    = 26,
  parameter int SH_W = 5
) (
  input  logic [W-1:0]    din,
  input  logic [SH_W-1:0] sh,
  output logic [W-1:0]    dout,
  output logic            lost
);

  logic [SH_W:0][W-1:0] stage;
  logic [SH_W:0]        drop;

  assign stage[0] = din;
  assign drop[0]  = 1'b0;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    if (STEP < W) begin : g_part
      assign stage[k+1] = sh[k] ? (stage[k] >> STEP) : stage[k];
      assign drop[k+1]  = drop[k] | (sh[k] & (|stage[k][STEP-1:0]));
    end else begin : g_full
      assign stage[k+1] = sh[k] ? '0 : stage[k];
      assign drop[k+1]  = drop[k] | (sh[k] & (|stage[k]));
    end
  end

  assign dout = stage[SH_W];
  assign lost = drop[SH_W];

endmodule

// File: rtl/fp32_round_inc.sv
// Rounding decision and increment for a significand with guard/round/sticky.
module fp32_round_inc
  import fp32_pack_pkg::*;
#(
  parameter int MW = 24
) (
  input  logic [MW-1:0] mant,
  input  logic          guard,
  input  logic          rnd,
  input  logic          sticky,
  input  logic          sign,
  input  logic [1:0]    rmode,
  output logic [MW:0]   sum,
  output logic          inexact
);

  logic up;

  always_comb begin
    inexact = guard | rnd | sticky;
    unique case (rmode)
      RM_NEAREST: up = guard & (rnd | sticky | mant[0]);
      RM_TOZERO:  up = 1'b0;
      RM_DOWN:    up = inexact & sign;
      RM_UP:      up = inexact & ~sign;
      default:    up = 1'b0;
    endcase
    sum = {1'b0, mant} + {{MW{1'b0}}, up};
  end

endmodule

// File: rtl/fp32_pack_core.sv
// Combinational packing: bias, denormalise, round, renormalise, overflow.
module fp32_pack_core
  import fp32_pack_pkg::*;
#(
  parameter int FW  = FRAC_W,
  parameter int EW  = EFLD_W,
  parameter int XW  = IEXP_W,
  localparam int WW = 1 + EW + FW
) (
  input  logic                 sign,
  input  logic [1:0]           cls,
  input  logic signed [XW-1:0] exp_in,
  input  logic [FW:0]          mant,
  input  logic                 guard,
  input  logic                 rnd,
  input  logic                 sticky,
  input  logic [1:0]           rmode,
  output logic [WW-1:0]        word,
  output fp_flags_t            flags
);

  localparam int MW   = FW + 1;
  localparam int VW   = MW + 2;
  localparam int SH_W = $clog2(VW + 1);
  localparam int BW   = XW + 2;
  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam int EMAX = (1 << EW) - 1;

  logic signed [BW-1:0] biased, deficit, exp_n;
  logic                 is_sub;
  logic [SH_W-1:0]      shamt;
  logic [VW-1:0]        sh_out;
  logic                 sh_lost;
  logic [MW:0]          sum;
  logic                 rnd_inx, carry, ovf, to_inf;
  logic [EW-1:0]        exp_fld;
  logic [FW-1:0]        frac_fld;

  // Bias and subnormal shift amount
  always_comb begin
    biased  = BW'(exp_in) + BW'(BIAS);
    is_sub  = biased[BW-1] | (biased == '0);
    deficit = BW'(1) - biased;
    if (!is_sub)
      shamt = '0;
    else if (deficit > BW'(VW))
      shamt = SH_W'(VW);
    else
      shamt = deficit[SH_W-1:0];
  end

  fp32_sticky_shift #(.W(VW), .SH_W(SH_W)) u_shift (
    .din  ({mant, guard, rnd}),
    .sh   (shamt),
    .dout (sh_out),
    .lost (sh_lost)
  );

  fp32_round_inc #(.MW(MW)) u_round (
    .mant    (sh_out[VW-1:2]),
    .guard   (sh_out[1]),
    .rnd     (sh_out[0]),
    .sticky  (sticky | sh_lost),
    .sign    (sign),
    .rmode   (rmode),
    .sum     (sum),
    .inexact (rnd_inx)
  );

  // Renormalise and range-check
  always_comb begin
    carry  = sum[MW];
    exp_n  = biased + $signed({{(BW-1){1'b0}}, carry});
    ovf    = ~is_sub & (exp_n >= BW'(EMAX));
    to_inf = (rmode == RM_NEAREST) |
             ((rmode == RM_UP) & ~sign) |
             ((rmode == RM_DOWN) & sign);
    if (is_sub) begin
      exp_fld  = sum[FW] ? EW'(1) : '0;
      frac_fld = sum[FW] ? '0 : sum[FW-1:0];
    end else begin
      exp_fld  = exp_n[EW-1:0];
      frac_fld = carry ? '0 : sum[FW-1:0];
    end
  end

  // Class selection and flag assembly
  always_comb begin
    flags = '0;
    unique case (cls)
      CLS_ZERO: word = {sign, {(WW-1){1'b0}}};
      CLS_INF:  word = {sign, {EW{1'b1}}, {FW{1'b0}}};
      CLS_NAN:  word = {sign, {EW{1'b1}}, mant[FW-1:0]};
      default: begin
        flags.inx = rnd_inx | ovf;
        flags.unf = is_sub;
        flags.ovf = ovf;
        flags.operr = ovf;
        if (!ovf)
          word = {sign, exp_fld, frac_fld};
        else if (to_inf)
          word = {sign, {EW{1'b1}}, {FW{1'b0}}};
        else
          word = {sign, {(EW-1){1'b1}}, 1'b0, {FW{1'b1}}};
      end
    endcase
  end

endmodule

// File: rtl/fp32_packer.sv
// Registered single-precision packer with valid/ready on both sides.
module fp32_packer
  import fp32_pack_pkg::*;
#(
  parameter int FW  = FRAC_W,
  parameter int EW  = EFLD_W,
  parameter int XW  = IEXP_W,
  localparam int WW = 1 + EW + FW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_sign,
  input  logic [1:0]    in_class,
  input  logic [XW-1:0] in_exp,
  input  logic [FW:0]   in_mant,
  input  logic          in_guard,
  input  logic          in_round,
  input  logic          in_sticky,
  input  logic [1:0]    in_rmode,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [WW-1:0] out_word,
  output logic [3:0]    out_flags
);

  localparam int EMAX = (1 << EW) - 1;

  logic [WW-1:0] core_word;
  fp_flags_t     core_flags;
  logic          take;

  fp32_pack_core #(.FW(FW), .EW(EW), .XW(XW)) u_core (
    .sign   (in_sign),
    .cls    (in_class),
    .exp_in (in_exp),
    .mant   (in_mant),
    .guard  (in_guard),
    .rnd    (in_round),
    .sticky (in_sticky),
    .rmode  (in_rmode),
    .word   (core_word),
    .flags  (core_flags)
  );

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_flags <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_word  <= core_word;
        out_flags <= core_flags;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // Output field views for the checks below
  logic [EW-1:0] o_exp;
  fp_flags_t     o_fl;
  assign o_exp = out_word[WW-2 -: EW];
  assign o_fl  = out_flags;

  AST_TAKE_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);  // R11
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_flags));  // R11
  AST_OPERR_IFF_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (o_fl.operr == o_fl.ovf));  // R9
  AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && o_fl.ovf |-> o_fl.inx);  // R9
  AST_OVF_TOP_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && o_fl.ovf |-> (o_exp >= EW'(EMAX - 1)));  // R10
  AST_UNF_LOW_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && o_fl.unf |-> (o_exp <= EW'(1)));  // R7
  AST_SPECIAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (o_exp == EW'(EMAX)) && !o_fl.ovf |-> (out_flags == 4'b0000));  // R2

endmodule

// File: tb/fp32_packer_tb.sv
`timescale 1ns/1ps
module fp32_packer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_sign = 1'b0;
  logic [1:0]  in_class = 2'b00;
  logic [9:0]  in_exp = '0;
  logic [23:0] in_mant = '0;
  logic        in_guard = 1'b0, in_round = 1'b0, in_sticky = 1'b0;
  logic [1:0]  in_rmode = 2'b00;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_word;
  logic [3:0]  out_flags;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  fp32_packer u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sign(in_sign), .in_class(in_class), .in_exp(in_exp), .in_mant(in_mant),
    .in_guard(in_guard), .in_round(in_round), .in_sticky(in_sticky),
    .in_rmode(in_rmode), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .out_flags(out_flags)
  );

  typedef struct packed {
    logic        sg;
    logic [1:0]  cl;
    logic [9:0]  ex;
    logic [23:0] mn;
    logic        g, r, s;
    logic [1:0]  rm;
    logic [31:0] w;
    logic [3:0]  fl;
    logic [7:0]  rq;
  } vec_t;

  // class: 0 zero 1 num 2 inf 3 nan; mode: 0 near 1 zero 2 down 3 up
  // flags: {operr, ovf, unf, inx}
  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 10'd5,       24'h123456, 1'b1, 1'b1, 1'b1, 2'd0, 32'h8000_0000, 4'h0, 8'd1}, // R1
    '{1'b0, 2'd0, 10'd0,       24'h800000, 1'b1, 1'b0, 1'b1, 2'd3, 32'h0000_0000, 4'h0, 8'd1}, // R1
    '{1'b0, 2'd2, 10'd0,       24'h800000, 1'b0, 1'b0, 1'b0, 2'd0, 32'h7F80_0000, 4'h0, 8'd2}, // R2
    '{1'b1, 2'd2, 10'd3,       24'h800001, 1'b1, 1'b1, 1'b0, 2'd2, 32'hFF80_0000, 4'h0, 8'd2}, // R2
    '{1'b1, 2'd3, 10'd0,       24'hC00001, 1'b1, 1'b0, 1'b0, 2'd0, 32'hFFC0_0001, 4'h0, 8'd3}, // R3
    '{1'b0, 2'd1, 10'd0,       24'h800000, 1'b0, 1'b0, 1'b0, 2'd0, 32'h3F80_0000, 4'h0, 8'd4}, // R4
    '{1'b1, 2'd1, 10'd0,       24'hC00000, 1'b0, 1'b0, 1'b0, 2'd1, 32'hBFC0_0000, 4'h0, 8'd4}, // R4
    '{1'b0, 2'd1, 10'd10,      24'h9A0000, 1'b0, 1'b0, 1'b0, 2'd0, 32'h449A_0000, 4'h0, 8'd4}, // R4
    '{1'b0, 2'd1, 10'd0,       24'h800001, 1'b1, 1'b0, 1'b0, 2'd0, 32'h3F80_0002, 4'h1, 8'd5}, // R5 tie odd
    '{1'b0, 2'd1, 10'd0,       24'h800002, 1'b1, 1'b0, 1'b0, 2'd0, 32'h3F80_0002, 4'h1, 8'd5}, // R5 tie even
    '{1'b0, 2'd1, 10'd0,       24'h800002, 1'b1, 1'b1, 1'b1, 2'd1, 32'h3F80_0002, 4'h1, 8'd5}, // R5 to zero
    '{1'b0, 2'd1, 10'd0,       24'h800002, 1'b0, 1'b0, 1'b1, 2'd3, 32'h3F80_0003, 4'h1, 8'd5}, // R5 up pos
    '{1'b1, 2'd1, 10'd0,       24'h800002, 1'b0, 1'b0, 1'b1, 2'd3, 32'hBF80_0002, 4'h1, 8'd5}, // R5 up neg
    '{1'b1, 2'd1, 10'd0,       24'h800002, 1'b0, 1'b1, 1'b0, 2'd2, 32'hBF80_0003, 4'h1, 8'd5}, // R5 down neg
    '{1'b0, 2'd1, 10'd0,       24'h800002, 1'b0, 1'b1, 1'b1, 2'd0, 32'h3F80_0002, 4'h1, 8'd5}, // R5 below half
    '{1'b0, 2'd1, 10'd0,       24'hFFFFFF, 1'b1, 1'b1, 1'b0, 2'd0, 32'h4000_0000, 4'h1, 8'd6}, // R6
    '{1'b0, 2'd1, 10'd128,     24'h800000, 1'b0, 1'b0, 1'b0, 2'd0, 32'h7F80_0000, 4'hD, 8'd9}, // R9
    '{1'b0, 2'd1, 10'd128,     24'h800000, 1'b0, 1'b0, 1'b0, 2'd1, 32'h7F7F_FFFF, 4'hD, 8'd10}, // R10
    '{1'b1, 2'd1, 10'd128,     24'h800000, 1'b0, 1'b0, 1'b0, 2'd2, 32'hFF80_0000, 4'hD, 8'd10}, // R10
    '{1'b1, 2'd1, 10'd128,     24'h800000, 1'b0, 1'b0, 1'b0, 2'd3, 32'hFF7F_FFFF, 4'hD, 8'd10}, // R10
    '{1'b0, 2'd1, 10'd128,     24'h800000, 1'b0, 1'b0, 1'b0, 2'd2, 32'h7F7F_FFFF, 4'hD, 8'd10}, // R10
    '{1'b0, 2'd1, 10'd127,     24'hFFFFFF, 1'b1, 1'b0, 1'b0, 2'd0, 32'h7F80_0000, 4'hD, 8'd9}, // R9 carry
    '{1'b0, 2'd1, 10'd127,     24'hFFFFFF, 1'b0, 1'b0, 1'b0, 2'd0, 32'h7F7F_FFFF, 4'h0, 8'd9}, // R9 edge
    '{1'b0, 2'd1, 10'(-127),   24'h800000, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0040_0000, 4'h2, 8'd7}, // R7
    '{1'b0, 2'd1, 10'(-130),   24'hC00000, 1'b0, 1'b0, 1'b0, 2'd0, 32'h000C_0000, 4'h2, 8'd7}, // R7
    '{1'b0, 2'd1, 10'(-149),   24'h800000, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0000_0001, 4'h2, 8'd7}, // R7
    '{1'b0, 2'd1, 10'(-150),   24'h800000, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0000_0000, 4'h3, 8'd7}, // R7 tie
    '{1'b0, 2'd1, 10'(-150),   24'h800001, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0000_0001, 4'h3, 8'd7}, // R7 sticky
    '{1'b0, 2'd1, 10'(-200),   24'hFFFFFF, 1'b0, 1'b0, 1'b0, 2'd3, 32'h0000_0001, 4'h3, 8'd7}, // R7 clamp
    '{1'b0, 2'd1, 10'(-127),   24'hFFFFFF, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0080_0000, 4'h3, 8'd8}, // R8
    '{1'b0, 2'd1, 10'(-127),   24'hFFFFFF, 1'b0, 1'b0, 1'b0, 2'd1, 32'h007F_FFFF, 4'h3, 8'd8}  // R8
  };

  task automatic check(input string what, input int rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_sign = v.sg; in_class = v.cl; in_exp = v.ex; in_mant = v.mn;
    in_guard = v.g; in_round = v.r; in_sticky = v.s; in_rmode = v.rm;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R11 watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("reset out_valid", 11, {31'd0, out_valid}, 32'd0);   // R11
    check("reset in_ready", 11, {31'd0, in_ready}, 32'd1);     // R11
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk with the output always drained
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check($sformatf("vec %0d valid", i), 11, {31'd0, out_valid}, 32'd1);
      check($sformatf("vec %0d word", i), int'(VECS[i].rq), out_word, VECS[i].w);
      check($sformatf("vec %0d flags", i), int'(VECS[i].rq), {28'd0, out_flags}, {28'd0, VECS[i].fl});
    end

    // R11: idle cycle drops out_valid
    in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    check("idle drops valid", 11, {31'd0, out_valid}, 32'd0);

    // R11: back-pressure holds the result and refuses input
    out_ready = 1'b0;
    drive(VECS[5]); in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    check("stall first word", 11, out_word, 32'h3F80_0000);
    check("stall in_ready low", 11, {31'd0, in_ready}, 32'd0);
    drive(VECS[6]);
    @(posedge clk); @(negedge clk);
    check("stall word held", 11, out_word, 32'h3F80_0000);
    check("stall valid held", 11, {31'd0, out_valid}, 32'd1);
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    check("drain takes next", 11, out_word, 32'hBFC0_0000);
    in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    check("drain empties", 11, {31'd0, out_valid}, 32'd0);

    // R11: reset in mid-stream clears valid
    drive(VECS[2]); in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("async reset clears valid", 11, {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule